// File: doc/BRIEF.md
# Two-Group Priority Interrupt Controller

This block collects interrupt requests from two groups of sources and tells the processor which one to service next. One group is the normal group with sixteen inputs. The other is the fast group with eight inputs, which drives its own request line to the processor. A rising edge on any input latches a pending bit. Software can also raise normal requests directly.

Each input has its own priority value, where a smaller value is more urgent. Each group has its own mask. From the pending inputs that are neither masked nor already in service, the block picks one winner per group and reports its number in a vector word.

The vector word can be read at two addresses. One read only looks at the winner. The other read also takes the winner: it clears the winner's pending bit and marks that input as in service. The in-service mark stays set until software writes the input number to the group's end-of-service register. All access goes through a simple register port with word addresses.

Top module: `prio_intc`

## Requirements
- R1: After reset, every normal priority reads 15 and every fast priority reads 7. Both mask registers read all ones, so every input is blocked. No request is pending or in service, both vector words read 0xFFFFFFFF, and both request lines are low.
- R2: A rising edge on an input sets that input's pending bit at the next clock edge. The bit stays set after the input falls. An input held high sets the bit only once, at its edge.
- R3: An input can win only if it is pending, not masked and not in service. Among those, the input with the smallest priority value wins, and on equal values the lower input number wins. The vector word holds the winner's number in bits 3:0 (normal) or bits 2:0 (fast), and all higher bits read 1.
- R4: With no possible winner, the vector word reads 0xFFFFFFFF. A group's request line is high exactly when that group has a winner.
- R5: A read at a vector look address (0 or 2) changes no pending bit and no in-service bit.
- R6: A read at a vector take address (1 normal, 3 fast) returns the vector word. If there is a winner, that read clears the winner's pending bit and sets its in-service bit. If there is no winner, the read changes nothing.
- R7: A write to an end-of-service register (9 normal, 10 fast) clears the in-service bit of the input whose number is in the low bits of the write data.
- R8: Mask bit k set to 1 keeps input k out of the winner choice. Its pending bit still latches, can still be read, and competes again once the mask bit is cleared.
- R9: Writing to the software set register (address 6) sets each normal pending bit whose data bit is 1. Data bits that are 0 have no effect, and fast pending bits are never touched.
- R10: While an input is in service, it cannot win. A new edge on that input still sets its pending bit, and the input competes again after its end-of-service write.
- R11: Priority registers can be written and read back. Normal input k sits at address 16+k with 4 bits, and fast input k sits at address 32+k with 3 bits.
- R12: Word address map: 4 and 5 hold the normal and fast masks (read and write); 7 and 8 read the normal and fast pending bits; 11 and 12 read the normal and fast in-service bits. Bit k of each of these registers belongs to input k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Reset, active low, synchronous |
| nSrc | input | 16 | Normal group request inputs, edge sensitive |
| fSrc | input | 8 | Fast group request inputs, edge sensitive |
| addr | input | 6 | Register word address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe, needed for the take reads to have their effect |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the current address, combinational |
| nIrq | output | 1 | Normal group request line to the processor |
| fIrq | output | 1 | Fast group request line to the processor |

## Verification
The bench builds the block with its default sizes: sixteen normal inputs with 4-bit priorities and eight fast inputs with 3-bit priorities. These sizes are small enough to sweep every input of both groups through the full sequence of edge, look, take and end-of-service. The bench then loads priority patterns with many equal values and drains a full group, which checks the whole take order, including every tie. Mask patterns, software sets, held levels, repeated edges during service and takes on an empty group cover the remaining corners of the winner choice.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 6;
  localparam int IDX_W_MAX = 5;

  // word addresses
  localparam int A_NVEC  = 0;
  localparam int A_NACK  = 1;
  localparam int A_FVEC  = 2;
  localparam int A_FACK  = 3;
  localparam int A_NMASK = 4;
  localparam int A_FMASK = 5;
  localparam int A_SWSET = 6;
  localparam int A_NPEND = 7;
  localparam int A_FPEND = 8;
  localparam int A_NEOI  = 9;
  localparam int A_FEOI  = 10;
  localparam int A_NINS  = 11;
  localparam int A_FINS  = 12;
  localparam int A_NPRIO = 16;
  localparam int A_FPRIO = 32;

  // strobes from the control module to one group datapath
  typedef struct packed {
    logic                 ack;
    logic                 maskWr;
    logic                 swWr;
    logic                 eoiWr;
    logic                 prioWr;
    logic [IDX_W_MAX-1:0] prioIdx;
  } grpStrb_t;

endpackage

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int N     = 16,
  parameter int PW    = 4,
  parameter bit SW_EN = 1'b0,
  localparam int IW   = $clog2(N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N-1:0]      src,
  input  grpStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              vecValid,
  output logic [IW-1:0]     vecIdx,
  output logic [N-1:0]      pendQ,
  output logic [N-1:0]      maskQ,
  output logic [N-1:0]      insQ,
  output logic [N*PW-1:0]   prioFlat
);

  logic [N-1:0]  prevQ;
  logic [N-1:0]  rise;
  logic [N-1:0]  swSet;
  logic [N-1:0]  ackHot;
  logic [N-1:0]  eoiHot;
  logic [N-1:0]  elig;
  logic [PW-1:0] prioQ [N];
  logic [PW-1:0] bestPrio;
  logic          unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:N];

  // edge capture
  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= src;
  end
  assign rise = src & ~prevQ;

  // software set path exists only where the group allows it
  generate
    if (SW_EN) begin : g_sw
      assign swSet = strb.swWr ? wrData[N-1:0] : '0;
    end else begin : g_nosw
      assign swSet = '0;
    end
  endgenerate

  assign ackHot = (strb.ack && vecValid) ? (N'(1) << vecIdx) : '0;
  assign eoiHot = strb.eoiWr ? (N'(1) << wrData[IW-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      insQ  <= '0;
      maskQ <= '1;
    end else begin
      pendQ <= (pendQ & ~ackHot) | rise | swSet;
      insQ  <= (insQ & ~eoiHot) | ackHot;
      if (strb.maskWr) maskQ <= wrData[N-1:0];
    end
  end

  generate
    for (genvar i = 0; i < N; i++) begin : g_prio
      always_ff @(posedge clk) begin
        if (!rstN) prioQ[i] <= '1;
        else if (strb.prioWr && (int'(strb.prioIdx) == i)) prioQ[i] <= wrData[PW-1:0];
      end
      assign prioFlat[i*PW +: PW] = prioQ[i];
    end
  endgenerate

  // winner choice: strict compare keeps the lower number on ties
  assign elig = pendQ & ~maskQ & ~insQ;

  always_comb begin
    vecValid = 1'b0;
    vecIdx   = '0;
    bestPrio = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!vecValid || (prioQ[i] < bestPrio))) begin
        vecValid = 1'b1;
        vecIdx   = IW'(i);
        bestPrio = prioQ[i];
      end
    end
  end

  // R6
  ack_sets_insrv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && vecValid) |=> insQ[$past(vecIdx)]);

  // R6
  empty_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && !vecValid && !strb.eoiWr) |=> $stable(insQ));

  // R3
  winner_elig_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (pendQ[vecIdx] && !maskQ[vecIdx] && !insQ[vecIdx]));

  // R7
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiWr && !strb.ack) |=> !insQ[$past(wrData[IW-1:0])]);

  generate
    for (genvar k = 0; k < N; k++) begin : g_chk
      // R2
      pend_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pendQ[k]) |-> ($past(src[k]) || $past(strb.swWr)));
    end
  endgenerate

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NN  = 16,
  parameter int FN  = 8,
  parameter int NPW = 4,
  parameter int FPW = 3,
  localparam int NIW = $clog2(NN),
  localparam int FIW = $clog2(FN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              nValid,
  input  logic [NIW-1:0]    nIdx,
  input  logic [NN-1:0]     nPend,
  input  logic [NN-1:0]     nMask,
  input  logic [NN-1:0]     nIns,
  input  logic [NN*NPW-1:0] nPrioFlat,
  input  logic              fValid,
  input  logic [FIW-1:0]    fIdx,
  input  logic [FN-1:0]     fPend,
  input  logic [FN-1:0]     fMask,
  input  logic [FN-1:0]     fIns,
  input  logic [FN*FPW-1:0] fPrioFlat,
  output grpStrb_t          nStrb,
  output grpStrb_t          fStrb,
  output logic [DATA_W-1:0] rdData
);

  int   addrI;
  int   nOff;
  int   fOff;
  logic nPrioHit;
  logic fPrioHit;

  assign addrI    = int'(addr);
  assign nOff     = addrI - A_NPRIO;
  assign fOff     = addrI - A_FPRIO;
  assign nPrioHit = (addrI >= A_NPRIO) && (addrI < A_NPRIO + NN);
  assign fPrioHit = (addrI >= A_FPRIO) && (addrI < A_FPRIO + FN);

  function automatic logic [DATA_W-1:0] vecWord(input logic valid, input logic [4:0] idx, input int iw);
    logic [DATA_W-1:0] w;
    w = '1;
    if (valid) begin
      for (int b = 0; b < iw; b++) w[b] = idx[b];
    end
    return w;
  endfunction

  always_comb begin
    nStrb         = '0;
    fStrb         = '0;
    nStrb.ack     = rdEn && (addrI == A_NACK);
    fStrb.ack     = rdEn && (addrI == A_FACK);
    nStrb.maskWr  = wrEn && (addrI == A_NMASK);
    fStrb.maskWr  = wrEn && (addrI == A_FMASK);
    nStrb.swWr    = wrEn && (addrI == A_SWSET);
    nStrb.eoiWr   = wrEn && (addrI == A_NEOI);
    fStrb.eoiWr   = wrEn && (addrI == A_FEOI);
    nStrb.prioWr  = wrEn && nPrioHit;
    fStrb.prioWr  = wrEn && fPrioHit;
    nStrb.prioIdx = nPrioHit ? IDX_W_MAX'(nOff) : '0;
    fStrb.prioIdx = fPrioHit ? IDX_W_MAX'(fOff) : '0;
  end

  always_comb begin
    rdData = '0;
    case (addrI)
      A_NVEC, A_NACK: rdData = vecWord(nValid, 5'(nIdx), NIW);
      A_FVEC, A_FACK: rdData = vecWord(fValid, 5'(fIdx), FIW);
      A_NMASK:        rdData = DATA_W'(nMask);
      A_FMASK:        rdData = DATA_W'(fMask);
      A_NPEND:        rdData = DATA_W'(nPend);
      A_FPEND:        rdData = DATA_W'(fPend);
      A_NINS:         rdData = DATA_W'(nIns);
      A_FINS:         rdData = DATA_W'(fIns);
      default: begin
        if (nPrioHit)      rdData = DATA_W'(nPrioFlat[nOff*NPW +: NPW]);
        else if (fPrioHit) rdData = DATA_W'(fPrioFlat[fOff*FPW +: FPW]);
      end
    endcase
  end

  // R5
  peek_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && ((addrI == A_NVEC) || (addrI == A_FVEC))) |-> (!nStrb.ack && !fStrb.ack));

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nStrb.ack, fStrb.ack, nStrb.maskWr, fStrb.maskWr, nStrb.swWr,
              nStrb.eoiWr, fStrb.eoiWr, nStrb.prioWr, fStrb.prioWr}));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NN  = 16,
  parameter int FN  = 8,
  parameter int NPW = 4,
  parameter int FPW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NN-1:0]     nSrc,
  input  logic [FN-1:0]     fSrc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              nIrq,
  output logic              fIrq
);

  localparam int NIW = $clog2(NN);
  localparam int FIW = $clog2(FN);

  grpStrb_t            nStrb;
  grpStrb_t            fStrb;
  logic                nValid;
  logic                fValid;
  logic [NIW-1:0]      nIdx;
  logic [FIW-1:0]      fIdx;
  logic [NN-1:0]       nPend;
  logic [NN-1:0]       nMask;
  logic [NN-1:0]       nIns;
  logic [FN-1:0]       fPend;
  logic [FN-1:0]       fMask;
  logic [FN-1:0]       fIns;
  logic [NN*NPW-1:0]   nPrioFlat;
  logic [FN*FPW-1:0]   fPrioFlat;

  intc_ctrl #(.NN(NN), .FN(FN), .NPW(NPW), .FPW(FPW)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .nValid(nValid), .nIdx(nIdx), .nPend(nPend), .nMask(nMask), .nIns(nIns), .nPrioFlat(nPrioFlat),
    .fValid(fValid), .fIdx(fIdx), .fPend(fPend), .fMask(fMask), .fIns(fIns), .fPrioFlat(fPrioFlat),
    .nStrb(nStrb), .fStrb(fStrb), .rdData(rdData)
  );

  intc_dp #(.N(NN), .PW(NPW), .SW_EN(1'b1)) normDp_i (
    .clk(clk), .rstN(rstN), .src(nSrc), .strb(nStrb), .wrData(wrData),
    .vecValid(nValid), .vecIdx(nIdx), .pendQ(nPend), .maskQ(nMask), .insQ(nIns), .prioFlat(nPrioFlat)
  );

  intc_dp #(.N(FN), .PW(FPW), .SW_EN(1'b0)) fastDp_i (
    .clk(clk), .rstN(rstN), .src(fSrc), .strb(fStrb), .wrData(wrData),
    .vecValid(fValid), .vecIdx(fIdx), .pendQ(fPend), .maskQ(fMask), .insQ(fIns), .prioFlat(fPrioFlat)
  );

  assign nIrq = nValid;
  assign fIrq = fValid;

endmodule

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
  import intc_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] nSrc = '0;
  logic [7:0]  fSrc = '0;
  logic [5:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        nIrq;
  logic        fIrq;

  int nChecks = 0;
  int nFail   = 0;

  // bench model of the requirements
  bit [15:0] mPend [2];
  bit [15:0] mMask [2];
  bit [15:0] mIns  [2];
  int        mPrio [2][16];

  always #2.5 clk = ~clk;

  prio_intc dut_i (
    .clk(clk), .rstN(rstN), .nSrc(nSrc), .fSrc(fSrc), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .nIrq(nIrq), .fIrq(fIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 6'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 6'(a); rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic int groupSize(input int g);
    return (g == 0) ? 16 : 8;
  endfunction

  // R3: smallest priority value wins, lower number on ties
  function automatic int winner(input int g);
    int best = -1;
    int bp   = 99;
    for (int i = 0; i < groupSize(g); i++)
      if (mPend[g][i] && !mMask[g][i] && !mIns[g][i] && (mPrio[g][i] < bp)) begin
        bp = mPrio[g][i]; best = i;
      end
    return best;
  endfunction

  function automatic logic [31:0] vecOf(input int g, input int w);
    if (w < 0) return 32'hFFFF_FFFF;
    return (g == 0) ? (32'hFFFF_FFF0 | 32'(w)) : (32'hFFFF_FFF8 | 32'(w));
  endfunction

  task automatic pulse(input int g, input logic [15:0] bits);
    @(negedge clk);
    if (g == 0) nSrc = nSrc | bits; else fSrc = fSrc | bits[7:0];
    @(negedge clk);
    if (g == 0) nSrc = nSrc & ~bits; else fSrc = fSrc & ~bits[7:0];
    mPend[g] = mPend[g] | (bits & ((g == 0) ? 16'hFFFF : 16'h00FF));
  endtask

  task automatic checkIrq(input int g, input string req);
    #1;
    check(req, 32'((g == 0) ? nIrq : fIrq), 32'(winner(g) >= 0));
  endtask

  task automatic peek(input int g, input string req);
    logic [31:0] d;
    busRd((g == 0) ? A_NVEC : A_FVEC, d);
    check(req, d, vecOf(g, winner(g)));
  endtask

  task automatic doAck(input int g);
    logic [31:0] d;
    int w;
    w = winner(g);
    busRd((g == 0) ? A_NACK : A_FACK, d);
    check("R6 take read value", d, vecOf(g, w));
    if (w >= 0) begin
      mPend[g][w] = 1'b0;
      mIns[g][w]  = 1'b1;
    end
  endtask

  task automatic doEoi(input int g, input int i);
    busWr((g == 0) ? A_NEOI : A_FEOI, 32'(i));
    mIns[g][i] = 1'b0;
  endtask

  task automatic checkRegs(input int g, input string req);
    logic [31:0] d;
    busRd((g == 0) ? A_NPEND : A_FPEND, d);
    check({req, " pending"}, d, 32'(mPend[g]));
    busRd((g == 0) ? A_NINS : A_FINS, d);
    check({req, " in-service"}, d, 32'(mIns[g]));
  endtask

  task automatic setMask(input int g, input logic [15:0] m);
    logic [15:0] mm;
    mm = m & ((g == 0) ? 16'hFFFF : 16'h00FF);
    busWr((g == 0) ? A_NMASK : A_FMASK, 32'(mm));
    mMask[g] = mm;
  endtask

  task automatic drainAll(input int g);
    for (int k = 0; k < 17; k++) if (winner(g) >= 0) doAck(g);
    for (int i = 0; i < groupSize(g); i++) if (mIns[g][i]) doEoi(g, i);
  endtask

  // watchdog
  initial begin
    #(5.0 * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int g = 0; g < 2; g++) begin
      mPend[g] = '0; mIns[g] = '0;
      mMask[g] = (g == 0) ? 16'hFFFF : 16'h00FF;
      for (int i = 0; i < 16; i++) mPrio[g][i] = (g == 0) ? 15 : 7;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1 nIrq", 32'(nIrq), 0);
    check("R1 fIrq", 32'(fIrq), 0);
    busRd(A_NVEC, d); check("R1 normal vector", d, 32'hFFFF_FFFF);
    busRd(A_FVEC, d); check("R1 fast vector", d, 32'hFFFF_FFFF);
    busRd(A_NMASK, d); check("R1 normal mask", d, 32'h0000_FFFF);
    busRd(A_FMASK, d); check("R1 fast mask", d, 32'h0000_00FF);
    for (int i = 0; i < 16; i++) begin busRd(A_NPRIO + i, d); check("R1 normal prio", d, 15); end
    for (int i = 0; i < 8; i++)  begin busRd(A_FPRIO + i, d); check("R1 fast prio", d, 7); end
    checkRegs(0, "R1"); checkRegs(1, "R1");

    // R8: masked after reset, an edge latches but raises nothing
    pulse(0, 16'h0010);
    checkIrq(0, "R8 masked no irq");
    peek(0, "R8 masked vector");
    checkRegs(0, "R8");
    setMask(0, 16'h0000);
    peek(0, "R8 unmasked vector");
    drainAll(0);
    setMask(1, 16'h0000);

    // R2 R3 R6 R7: every input of each group through edge, look, take, end
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < groupSize(g); i++) begin
        pulse(g, 16'(1) << i);
        checkRegs(g, "R2 edge latched");
        checkIrq(g, "R4 irq with winner");
        peek(g, "R3 single input vector");
        doAck(g);
        checkIrq(g, "R4 irq after take");
        checkRegs(g, "R6 after take");
        doEoi(g, i);
        checkRegs(g, "R7 after end");
      end
    end

    // R11 R3: tied priority patterns, full drain order
    for (int i = 0; i < 16; i++) begin
      mPrio[0][i] = (i * 3 + 1) % 8;
      busWr(A_NPRIO + i, 32'(mPrio[0][i]));
    end
    for (int i = 0; i < 8; i++) begin
      mPrio[1][i] = (i * 5) % 4;
      busWr(A_FPRIO + i, 32'(mPrio[1][i]));
    end
    for (int i = 0; i < 16; i++) begin busRd(A_NPRIO + i, d); check("R11 normal prio readback", d, 32'(mPrio[0][i])); end
    for (int i = 0; i < 8; i++)  begin busRd(A_FPRIO + i, d); check("R11 fast prio readback", d, 32'(mPrio[1][i])); end
    for (int g = 0; g < 2; g++) begin
      pulse(g, 16'hFFFF);
      for (int k = 0; k < groupSize(g); k++) begin
        peek(g, "R3 ordered vector");
        doAck(g);
        checkIrq(g, "R4 irq during drain");
      end
      peek(g, "R4 empty after drain");
      checkRegs(g, "R6 all taken");
      for (int i = 0; i < groupSize(g); i++) doEoi(g, i);
      checkRegs(g, "R7 all ended");
    end

    // R8: partial mask, then release
    for (int g = 0; g < 2; g++) begin
      setMask(g, 16'hA5A5);
      pulse(g, 16'hFFFF);
      checkRegs(g, "R8 masked still latched");
      for (int k = 0; k < 17; k++) if (winner(g) >= 0) doAck(g);
      peek(g, "R8 only masked left");
      checkIrq(g, "R8 irq low with masked only");
      setMask(g, 16'h0000);
      peek(g, "R8 released vector");
      drainAll(g);
    end

    // R9: software set
    busWr(A_SWSET, 32'h0000_0000);
    checkRegs(0, "R9 zero write");
    busWr(A_SWSET, 32'h0000_8001);
    mPend[0] = mPend[0] | 16'h8001;
    checkRegs(0, "R9 set bits");
    checkRegs(1, "R9 fast untouched");
    peek(0, "R9 vector");
    drainAll(0);

    // R2: held level latches once
    @(negedge clk); nSrc[3] = 1'b1;
    mPend[0][3] = 1'b1;
    repeat (3) @(negedge clk);
    doAck(0);
    repeat (4) @(negedge clk);
    checkRegs(0, "R2 held level no relatch");
    @(negedge clk); nSrc[3] = 1'b0;
    doEoi(0, 3);

    // R10: in-service input blocked, request still latches
    for (int g = 0; g < 2; g++) begin
      pulse(g, 16'h0002);
      doAck(g);
      pulse(g, 16'h0002);
      checkRegs(g, "R10 relatched while in service");
      peek(g, "R10 blocked vector");
      checkIrq(g, "R10 irq low");
      doEoi(g, 1);
      peek(g, "R10 after end");
      drainAll(g);
    end

    // R5: look reads have no effect
    pulse(0, 16'h0020);
    pulse(1, 16'h0004);
    for (int k = 0; k < 3; k++) begin peek(0, "R5 look normal"); peek(1, "R5 look fast"); end
    checkRegs(0, "R5 normal unchanged");
    checkRegs(1, "R5 fast unchanged");
    drainAll(0);
    drainAll(1);

    // R6: take on empty group changes nothing
    doAck(0);
    doAck(1);
    checkRegs(0, "R6 empty take normal");
    checkRegs(1, "R6 empty take fast");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule